// File: doc/BRIEF.md
# Single-Channel Paced Buffer DMA Controller

This block moves 16-bit words between a peripheral data bus and an external asynchronous static RAM without processor help. A host first loads a start address and a transfer count through a small parallel register port, then writes the control register last to arm the channel. After that, each rising edge of an external rate strobe starts one memory access. The strobe comes from a programmable clock source, and its profile is chosen by three control bits that the block drives out on pins.

A direction bit selects the flow. With the bit set, the block captures the word on the peripheral input bus and writes it to SRAM. With the bit clear, the block reads SRAM and presents the word to the peripheral with a one-cycle valid pulse. The address increments after every access. When the last word of a block is done, a terminal-count pulse fires and a sticky flag is set. The channel then either disarms or, in repeat mode, reloads its address and count and runs the same block again. Every memory access is held for two core clocks, which matches a core clock of at least twice the SRAM access rate.

Top module: `dma_buf_ctrl`

## Requirements
- R1: Register port: select 0 is the start address, 1 is the transfer count (desired transfers minus one), 2 is control and 3 reads the current address (writes to 3 are ignored). All are 23 bits. Control bit fields: bits 2:0 are the profile, bit 4 is the direction, bit 7 is arm/busy, bit 8 is repeat and bit 9 is the read-only terminal flag. Bits 3, 5 and 6 and bits above 9 read as 0. After reset every register reads 0.
- R2: Writing control with bit 7 = 1 arms the channel. It loads the current address from the start address and the working count from the count register, and clears the terminal flag, so bit 7 then reads 1. Writing control with bit 7 = 0 disarms the channel and abandons any access in progress. A control write takes priority over a transfer step in the same cycle.
- R3: The rate strobe passes through a two-flop synchronizer. Each rising edge seen while the channel is armed and idle starts one access, with the SRAM chip enable going low in the third clock after the strobe is first sampled high. Edges seen while disarmed or during an access are ignored.
- R4: With direction 1 (device to memory), the peripheral input word is captured at the start of the access. Write enable is held low for exactly two clocks at the current address, and the address then increments by one.
- R5: With direction 0 (memory to device), output enable is held low for exactly two clocks at the current address. The read word then appears on the peripheral output together with a one-clock valid pulse, and the address increments by one.
- R6: A count value of N-1 gives exactly N accesses. The terminal-count output pulses for one clock as the Nth access completes.
- R7: Terminal count sets the sticky flag (control bit 9). Without repeat, it clears bit 7, and later strobes cause no access.
- R8: With repeat (control bit 8), terminal count reloads the current address from the start address and the working count from the count register. Bit 7 stays 1.
- R9: The three profile bits drive the clk_profile pins directly.
- R10: Chip enable is low only during an access, the address is stable across both clocks of an access, and write enable and output enable are never low together.
- R11: The current address wraps from 0x7FFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 23 | Register write data |
| reg_rdata | output | 23 | Readback of the selected register |
| rate_in | input | 1 | Asynchronous transfer rate strobe |
| clk_profile | output | 3 | Reference clock profile select |
| periph_din | input | 16 | Word from the peripheral |
| periph_dout | output | 16 | Word to the peripheral |
| periph_dout_valid | output | 1 | One-clock pulse when periph_dout is new |
| sram_addr | output | 23 | SRAM address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| tc_out | output | 1 | Terminal-count pulse |

## Verification
A wrong current address or working count shows at the SRAM address pins on the very next access. It also shows in the register readback of select 3 within one clock, and a count error moves the terminal-count pulse by a whole access. A wrong access state shows within one clock as an enable held for one or three cycles, or as an access starting when no strobe edge arrived. Because the reference model is compared on every clock, a divergence is reported in the cycle it first appears, rather than only at the end of a block.

// File: rtl/dma_buf_ctrl.sv
module dma_buf_ctrl #(
  parameter int AW   = 23,
  parameter int DW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          rate_in,
  output logic [2:0]    clk_profile,
  input  logic [DW-1:0] periph_din,
  output logic [DW-1:0] periph_dout,
  output logic          periph_dout_valid,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          tc_out
);
  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam int B_DIR  = 4;
  localparam int B_ARM  = 7;
  localparam int B_REP  = 8;
  localparam int B_TCF  = 9;

  typedef enum logic [1:0] {S_IDLE, S_ACC1, S_ACC2} state_t;

  state_t          state;
  logic [AW-1:0]   start_q, count_q, addr_q, left_q;
  logic [2:0]      prof_q;
  logic            dir_q, busy_q, rep_q, tcf_q;
  logic [SYNC:0]   sync_q;
  logic [DW-1:0]   wbuf_q;
  logic            edge_seen, ctl_wr, last;

  assign edge_seen = sync_q[SYNC-1] & ~sync_q[SYNC];
  assign ctl_wr    = reg_wr && reg_sel == SEL_CTRL;
  assign last      = left_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-1:0], rate_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_START) start_q <= reg_wdata;
      if (reg_sel == SEL_COUNT) count_q <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      prof_q <= '0;
      dir_q <= 1'b0;
      busy_q <= 1'b0;
      rep_q <= 1'b0;
      tcf_q <= 1'b0;
      wbuf_q <= '0;
      periph_dout <= '0;
      periph_dout_valid <= 1'b0;
      tc_out <= 1'b0;
    end else begin
      periph_dout_valid <= 1'b0;
      tc_out <= 1'b0;
      if (ctl_wr) begin
        prof_q <= reg_wdata[2:0];
        dir_q  <= reg_wdata[B_DIR];
        rep_q  <= reg_wdata[B_REP];
        busy_q <= reg_wdata[B_ARM];
        state  <= S_IDLE;
        if (reg_wdata[B_ARM]) begin
          addr_q <= start_q;
          left_q <= count_q;
          tcf_q  <= 1'b0;
        end
      end else begin
        case (state)
          S_IDLE: if (busy_q && edge_seen) begin
            state <= S_ACC1;
            if (dir_q) wbuf_q <= periph_din;
          end
          S_ACC1: state <= S_ACC2;
          S_ACC2: begin
            state <= S_IDLE;
            if (!dir_q) begin
              periph_dout <= sram_rdata;
              periph_dout_valid <= 1'b1;
            end
            if (last) begin
              tc_out <= 1'b1;
              tcf_q  <= 1'b1;
              if (rep_q) begin
                addr_q <= start_q;
                left_q <= count_q;
              end else begin
                busy_q <= 1'b0;
              end
            end else begin
              addr_q <= addr_q + 1'b1;
              left_q <= left_q - 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign clk_profile = prof_q;
  assign sram_addr   = addr_q;
  assign sram_wdata  = wbuf_q;
  assign sram_ce_n   = state == S_IDLE;
  assign sram_we_n   = !(dir_q && state != S_IDLE);
  assign sram_oe_n   = !(!dir_q && state != S_IDLE);

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_START: reg_rdata = start_q;
      SEL_COUNT: reg_rdata = count_q;
      SEL_CTRL: begin
        reg_rdata[2:0]   = prof_q;
        reg_rdata[B_DIR] = dir_q;
        reg_rdata[B_ARM] = busy_q;
        reg_rdata[B_REP] = rep_q;
        reg_rdata[B_TCF] = tcf_q;
      end
      default: reg_rdata = addr_q;
    endcase
  end

  a_r10_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  a_r4_write_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_we_n) && !$past(ctl_wr)) |-> !$past(sram_we_n, 2));
  a_r5_read_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_oe_n) && !$past(ctl_wr)) |-> !$past(sram_oe_n, 2));
  a_r3_start_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sram_ce_n)) |-> ($past(edge_seen) && $past(busy_q)));
  a_r7_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sram_ce_n);
  a_r7_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> tcf_q);
  a_r7_tc_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_out && !rep_q) |-> !busy_q);
  a_r8_repeat_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_out && rep_q) |-> (busy_q && sram_addr == start_q));
  a_r5_valid_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    periph_dout_valid |-> !dir_q);
endmodule

// File: tb/test_dma_buf_ctrl.sv
module test_dma_buf_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [22:0] reg_wdata = 0, reg_rdata;
  logic rate_in = 0;
  logic [2:0] clk_profile;
  logic [15:0] periph_din = 0, periph_dout, sram_wdata;
  logic [15:0] sram_rdata;
  logic periph_dout_valid, sram_ce_n, sram_we_n, sram_oe_n, tc_out;
  logic [22:0] sram_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mem [64];

  always #5 clk = ~clk;

  dma_buf_ctrl i_dma_buf_ctrl (.*);

  always_comb sram_rdata = !sram_oe_n ? mem[sram_addr[5:0]] : 16'hDEAD;
  always @(posedge clk) if (rst_n && !sram_we_n) mem[sram_addr[5:0]] <= sram_wdata;

  // reference model
  logic s1, s2, s3, m_busy, m_dir, m_rep, m_tcf, m_tc, m_dv;
  logic [2:0] m_prof;
  logic [22:0] m_sar, m_tcr, m_mar, m_cnt;
  logic [15:0] m_wd, m_dout;
  int m_st;

  function automatic logic [22:0] m_read(input logic [1:0] s);
    case (s)
      0: return m_sar;
      1: return m_tcr;
      2: return 23'(m_tcf) << 9 | 23'(m_rep) << 8 | 23'(m_busy) << 7 | 23'(m_dir) << 4 | 23'(m_prof);
      default: return m_mar;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; s3 = 0; m_busy = 0; m_dir = 0; m_rep = 0; m_tcf = 0;
      m_tc = 0; m_dv = 0; m_prof = 0; m_sar = 0; m_tcr = 0; m_mar = 0;
      m_cnt = 0; m_wd = 0; m_dout = 0; m_st = 0;
    end else begin
      logic edg;
      edg = s2 && !s3;
      s3 = s2; s2 = s1; s1 = rate_in;
      m_tc = 0; m_dv = 0;
      if (reg_wr && reg_sel == 2) begin
        m_prof = reg_wdata[2:0]; m_dir = reg_wdata[4]; m_rep = reg_wdata[8];
        m_busy = reg_wdata[7]; m_st = 0;
        if (reg_wdata[7]) begin m_mar = m_sar; m_cnt = m_tcr; m_tcf = 0; end
      end else if (m_st == 0) begin
        if (m_busy && edg) begin m_st = 1; if (m_dir) m_wd = periph_din; end
      end else if (m_st == 1) m_st = 2;
      else begin
        m_st = 0;
        if (!m_dir) begin m_dout = mem[m_mar[5:0]]; m_dv = 1; end
        if (m_cnt == 0) begin
          m_tc = 1; m_tcf = 1;
          if (m_rep) begin m_mar = m_sar; m_cnt = m_tcr; end else m_busy = 0;
        end else begin m_mar = m_mar + 1; m_cnt = m_cnt - 1; end
      end
      if (reg_wr && reg_sel == 0) m_sar = reg_wdata;
      if (reg_wr && reg_sel == 1) m_tcr = reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    #1;
    chk("R10 ce_n", 32'(sram_ce_n), 32'(m_st == 0));
    chk("R4 we_n", 32'(sram_we_n), 32'(!(m_dir && m_st != 0)));
    chk("R5 oe_n", 32'(sram_oe_n), 32'(!(!m_dir && m_st != 0)));
    if (m_st != 0) chk("R4 addr", 32'(sram_addr), 32'(m_mar));
    if (!sram_we_n) chk("R4 wdata", 32'(sram_wdata), 32'(m_wd));
    chk("R6 tc_out", 32'(tc_out), 32'(m_tc));
    chk("R5 valid", 32'(periph_dout_valid), 32'(m_dv));
    if (m_dv) chk("R5 dout", 32'(periph_dout), 32'(m_dout));
    chk("R9 profile", 32'(clk_profile), 32'(m_prof));
    chk("R1 readback", 32'(reg_rdata), 32'(m_read(reg_sel)));
  end

  task automatic wr(input logic [1:0] s, input logic [22:0] v);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_wr = 0; reg_sel = 2;
  endtask

  task automatic strobe(input logic [15:0] d);
    @(negedge clk); periph_din = d; rate_in = 1;
    repeat (3) @(negedge clk);
    rate_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, input string tag, input logic [22:0] exp);
    @(negedge clk); reg_sel = s; #2;
    chk(tag, 32'(reg_rdata), 32'(exp));
    reg_sel = 2;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(16'h1000 + i);
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset rdata", 32'(reg_rdata), 0);
    chk("R10 reset ce_n", 32'(sram_ce_n), 1);
    rst_n = 1;
    // R1 register readback and reserved bits
    wr(0, 23'h7FFFFF); rd(0, "R1 start", 23'h7FFFFF);
    wr(1, 23'h12345);  rd(1, "R1 count", 23'h12345);
    wr(2, 23'h7FFF6D); rd(2, "R1 ctrl reserved zero", 23'h000105);
    wr(3, 23'h55);     rd(3, "R1 addr write ignored", 23'h0);
    wr(2, 23'h000);
    // R3 strobe while disarmed ignored
    strobe(16'hBEEF);
    chk("R3 no access disarmed", 32'(mem[0]), 32'h1000);
    // R4 R6 R7 device to memory, 4 words at 10
    wr(0, 10); wr(1, 3); wr(2, 23'h096);
    rd(2, "R2 armed busy", 23'h096);
    rd(3, "R2 addr loaded", 10);
    for (int i = 0; i < 4; i++) strobe(16'(16'hA000 + i));
    for (int i = 0; i < 4; i++) chk("R4 mem written", 32'(mem[10 + i]), 32'(16'hA000 + i));
    rd(2, "R7 tc flag and disarm", 23'h216);
    strobe(16'hFFFF);
    chk("R7 ignored after tc", 32'(mem[14]), 32'(16'h100E));
    // R5 R8 memory to device with repeat
    wr(0, 20); wr(1, 1); wr(2, 23'h183);
    rd(2, "R2 tc flag cleared on arm", 23'h183);
    for (int i = 0; i < 5; i++) strobe(0);
    rd(2, "R8 still busy", 23'h383);
    rd(3, "R8 addr reloaded", 21);
    // R2 disarm mid access
    @(negedge clk); rate_in = 1; repeat (3) @(negedge clk); rate_in = 0;
    wr(2, 23'h003);
    rd(2, "R2 disarmed", 23'h203);
    repeat (4) @(negedge clk);
    // R11 wrap
    wr(0, 23'h7FFFFE); wr(1, 2); wr(2, 23'h090);
    for (int i = 0; i < 3; i++) strobe(16'(16'hC000 + i));
    chk("R11 wrap to zero", 32'(mem[0]), 32'hC002);
    chk("R11 top word", 32'(mem[63]), 32'hC001);
    // R3 edge during access ignored: fast double pulse
    wr(0, 30); wr(1, 5); wr(2, 23'h090);
    @(negedge clk); periph_din = 16'hD000; rate_in = 1; @(negedge clk); rate_in = 0;
    @(negedge clk); rate_in = 1; @(negedge clk); rate_in = 0;
    repeat (6) @(negedge clk);
    rd(3, "R3 one access per two quick edges", 31);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule